// File: doc/BRIEF.md
# Autoranging Gated Frequency Counter

This block measures the frequency of an asynchronous pulse stream against a synchronous reference clock. The input is synchronised and its rising edges are found. A counting window is then opened for a known number of reference clock cycles, and the edges that fall inside that window are counted. The window length is the frequency scale.

The block picks its own window. Each measurement begins with the shortest window, nominally 1 ms. If that window holds too few edges for good resolution, the block repeats the measurement with a window ten times longer: 10 ms, then 100 ms, then 1 s. It publishes the first count that exceeds a fixed threshold. The 1 s result is always published.

A published result consists of three things: the count, a two-bit code naming the window that produced it, and an overflow flag. A one-cycle valid strobe marks each new result. The count can also be read one half at a time through a byte-select input, for a narrow consumer. The window base length is a parameter, so simulation can use short windows. The threshold and the count width are parameters as well.

Top module: `freq_autorange`

## Requirements
- R1: While reset is held, and until the first result is published, valid, count, range_code, overflow and count_byte read 0.
- R2: Every measurement sequence starts with range code 0, a window of BASE_TICKS cycles. A result published at range 0 is followed by the next valid pulse exactly BASE_TICKS+2 cycles later. The range codes are 0 for 1 ms, 1 for 10 ms, 2 for 100 ms and 3 for 1 s.
- R3: When a window ends with a count above THRESH, that count is published with the current range code. The count equals the number of rising input edges seen inside that window.
- R4: When a window ends with a count of THRESH or less, and the range is below 3, nothing is published. The next window uses the next range code and is ten times longer. A count exactly equal to THRESH steps up.
- R5: A range 3 window is always published, even with a count below THRESH, including a count of 0.
- R6: After every publish the next measurement starts again at range 0. After a result is published at range 1, the next valid pulse follows (BASE_TICKS+2)+(10*BASE_TICKS+2) cycles later, again at range 1.
- R7: The edge counter is cleared before each window opens. A published count contains only edges from its own window and none from the shorter windows tried before it.
- R8: If the count would pass its all-ones value, it holds at all ones and the overflow flag is set. An overflowed window is published at once, with overflow = 1.
- R9: valid is high for exactly one cycle per result. count, range_code and overflow stay unchanged between valid pulses.
- R10: One cycle after hi_sel is sampled, count_byte shows the published count. With hi_sel = 0 it shows bits [CNT_W/2-1:0]. With hi_sel = 1 it shows bits [CNT_W-1:CNT_W/2].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| sig_in | input | 1 | Asynchronous signal being measured |
| hi_sel | input | 1 | Selects the upper half of the count on count_byte |
| count | output | CNT_W | Published edge count |
| count_byte | output | CNT_W/2 | Selected half of the published count |
| range_code | output | 2 | Window that produced the result (0..3) |
| overflow | output | 1 | Count saturated during the published window |
| valid | output | 1 | One-cycle strobe marking a new result |

## Verification
Input periods are chosen so that each range ends the autoranging search: a fast stream stops at range 0, two slower streams stop at ranges 1 and 2, and a very slow stream and a silent input reach range 3. Each period divides the window lengths exactly, so the expected counts are exact. These counts separate a correct per-window clear from accumulated counts. A period that gives exactly the threshold count at range 0 shows that equality steps up, and its tenfold count then exercises saturation. The spacing between consecutive valid pulses, measured in clock cycles, checks both the window lengths and the restart at range 0.

// File: rtl/freq_pkg.sv
`timescale 1ns/1ps
package freq_pkg;
  localparam int NUM_RANGES = 4;
  localparam int RANGE_W    = 2;

  typedef enum logic [1:0] {
    ST_CLEAR = 2'd0,
    ST_GATE  = 2'd1,
    ST_DECIDE = 2'd2
  } meas_state_t;

  function automatic longint gate_len(input longint base, input int step);
    longint v;
    v = base;
    for (int i = 0; i < step; i++) v = v * 10;
    return v;
  endfunction
endpackage

// File: rtl/freq_sig_sync.sv
`timescale 1ns/1ps
module freq_sig_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sig_in,
  output logic rise
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-1:0], sig_in};
  end

  assign rise = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/freq_gate_timer.sv
`timescale 1ns/1ps
module freq_gate_timer
  import freq_pkg::*;
#(
  parameter int BASE_TICKS = 50000,
  parameter int TMR_W      = 26
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  input  logic               run,
  input  logic [RANGE_W-1:0] range_sel,
  output logic               last
);
  logic [TMR_W-1:0] limit [NUM_RANGES];
  logic [TMR_W-1:0] tick;

  for (genvar g = 0; g < NUM_RANGES; g++) begin : g_lim
    assign limit[g] = TMR_W'(gate_len(longint'(BASE_TICKS), g) - 1);
  end

  always_ff @(posedge clk) begin
    if (rst || clr) tick <= '0;
    else if (run)   tick <= tick + 1'b1;
  end

  assign last = run && (tick == limit[range_sel]);
endmodule

// File: rtl/freq_edge_count.sv
`timescale 1ns/1ps
module freq_edge_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] value,
  output logic             sat
);
  localparam logic [CNT_W-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      value <= '0;
      sat   <= 1'b0;
    end else if (inc) begin
      if (value == TOP) sat <= 1'b1;
      else              value <= value + 1'b1;
    end
  end
endmodule

// File: rtl/freq_range_ctrl.sv
`timescale 1ns/1ps
module freq_range_ctrl
  import freq_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int THRESH = 4096
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               win_last,
  input  logic [CNT_W-1:0]   win_count,
  input  logic               win_sat,
  output logic               cnt_clr,
  output logic               gate_on,
  output logic [RANGE_W-1:0] cur_range,
  output logic [CNT_W-1:0]   res_count,
  output logic [RANGE_W-1:0] res_range,
  output logic               res_ovf,
  output logic               res_valid
);
  localparam logic [CNT_W:0]   THR_V    = (CNT_W+1)'(THRESH);
  localparam logic [RANGE_W-1:0] LAST_RNG = RANGE_W'(NUM_RANGES - 1);

  meas_state_t state;
  logic        enough;

  assign cnt_clr = (state == ST_CLEAR);
  assign gate_on = (state == ST_GATE);
  assign enough  = win_sat || ({1'b0, win_count} > THR_V) || (cur_range == LAST_RNG);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_CLEAR;
      cur_range <= '0;
      res_count <= '0;
      res_range <= '0;
      res_ovf   <= 1'b0;
      res_valid <= 1'b0;
    end else begin
      res_valid <= 1'b0;
      case (state)
        ST_CLEAR: state <= ST_GATE;
        ST_GATE:  if (win_last) state <= ST_DECIDE;
        ST_DECIDE: begin
          state <= ST_CLEAR;
          if (enough) begin
            res_count <= win_count;
            res_range <= cur_range;
            res_ovf   <= win_sat;
            res_valid <= 1'b1;
            cur_range <= '0;
          end else begin
            cur_range <= cur_range + 1'b1;
          end
        end
        default: state <= ST_CLEAR;
      endcase
    end
  end
endmodule

// File: rtl/freq_autorange.sv
`timescale 1ns/1ps
module freq_autorange
  import freq_pkg::*;
#(
  parameter int BASE_TICKS  = 50000,
  parameter int CNT_W       = 16,
  parameter int THRESH      = 4096,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sig_in,
  input  logic               hi_sel,
  output logic [CNT_W-1:0]   count,
  output logic [CNT_W/2-1:0] count_byte,
  output logic [1:0]         range_code,
  output logic               overflow,
  output logic               valid
);
  localparam int     HALF    = CNT_W / 2;
  localparam longint LONGEST = gate_len(longint'(BASE_TICKS), NUM_RANGES - 1);
  localparam int     TMR_W   = $clog2(LONGEST + 1);

  logic               rise;
  logic               cnt_clr;
  logic               gate_on;
  logic               win_last;
  logic [RANGE_W-1:0] cur_range;
  logic [CNT_W-1:0]   edge_cnt;
  logic               edge_sat;

  freq_sig_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .sig_in(sig_in), .rise(rise)
  );

  freq_gate_timer #(.BASE_TICKS(BASE_TICKS), .TMR_W(TMR_W)) u_timer (
    .clk(clk), .rst(rst), .clr(cnt_clr), .run(gate_on),
    .range_sel(cur_range), .last(win_last)
  );

  freq_edge_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst(rst), .clr(cnt_clr), .inc(rise & gate_on),
    .value(edge_cnt), .sat(edge_sat)
  );

  freq_range_ctrl #(.CNT_W(CNT_W), .THRESH(THRESH)) u_ctrl (
    .clk(clk), .rst(rst), .win_last(win_last), .win_count(edge_cnt),
    .win_sat(edge_sat), .cnt_clr(cnt_clr), .gate_on(gate_on),
    .cur_range(cur_range), .res_count(count), .res_range(range_code),
    .res_ovf(overflow), .res_valid(valid)
  );

  always_ff @(posedge clk) begin
    if (rst)         count_byte <= '0;
    else if (hi_sel) count_byte <= count[CNT_W-1:HALF];
    else             count_byte <= count[HALF-1:0];
  end
endmodule

// File: rtl/freq_autorange_chk.sv
`timescale 1ns/1ps
module freq_autorange_chk #(
  parameter int CNT_W  = 16,
  parameter int THRESH = 4096
) (
  input logic             clk,
  input logic             rst,
  input logic             valid,
  input logic [CNT_W-1:0] count,
  input logic [1:0]       range_code,
  input logic             overflow,
  input logic [1:0]       cur_range,
  input logic             cnt_clr,
  input logic [CNT_W-1:0] edge_cnt
);
  localparam logic [CNT_W:0] THR_V = (CNT_W+1)'(THRESH);

  // R9
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    valid |=> !valid);

  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !valid |-> ($stable(count) && $stable(range_code) && $stable(overflow)));

  // R8
  overflow_sat_chk: assert property (@(posedge clk) disable iff (rst)
    overflow |-> (count == {CNT_W{1'b1}}));

  // R4
  publish_rule_chk: assert property (@(posedge clk) disable iff (rst)
    (valid && range_code != 2'd3) |-> (overflow || ({1'b0, count} > THR_V)));

  // R6
  restart_chk: assert property (@(posedge clk) disable iff (rst)
    valid |-> (cur_range == 2'd0));

  // R7
  window_clear_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_clr |=> (edge_cnt == '0));
endmodule

bind freq_autorange freq_autorange_chk #(.CNT_W(CNT_W), .THRESH(THRESH)) u_chk (
  .clk(clk), .rst(rst), .valid(valid), .count(count), .range_code(range_code),
  .overflow(overflow), .cur_range(cur_range), .cnt_clr(cnt_clr), .edge_cnt(edge_cnt)
);

// File: tb/freq_autorange_test.sv
`timescale 1ns/1ps
module freq_autorange_test;
  localparam int BASE = 40;
  localparam int W    = 6;
  localparam int TH   = 8;
  localparam int NV   = 6;
  localparam int WAIT_LIMIT = 60000;

  // vector columns: high cycles, low cycles, expected range, count, overflow
  localparam int V_HI [NV] = '{1, 2, 3, 5, 50, 1000};
  localparam int V_LO [NV] = '{1, 2, 2, 5, 50, 1000};
  localparam int V_RG [NV] = '{0, 0, 1, 1, 2, 3};
  localparam int V_CT [NV] = '{20, 10, 63, 40, 40, 20};
  localparam int V_OV [NV] = '{0, 0, 1, 0, 0, 0};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sig_in = 1'b0;
  logic hi_sel = 1'b0;
  logic [W-1:0]   count;
  logic [W/2-1:0] count_byte;
  logic [1:0]     range_code;
  logic           overflow;
  logic           valid;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int hv = 0;
  int lv = 0;
  int gen_ticks = 0;

  freq_autorange #(.BASE_TICKS(BASE), .CNT_W(W), .THRESH(TH)) uut (
    .clk(clk), .rst(rst), .sig_in(sig_in), .hi_sel(hi_sel), .count(count),
    .count_byte(count_byte), .range_code(range_code), .overflow(overflow),
    .valid(valid)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  initial begin
    forever begin
      if (hv == 0) begin
        sig_in = 1'b0;
        gen_ticks++;
        @(negedge clk);
      end else begin
        gen_ticks++;
        sig_in = 1'b1;
        repeat (hv) @(negedge clk);
        sig_in = 1'b0;
        repeat (lv) @(negedge clk);
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_input(input int h, input int l);
    int g0;
    hv = h;
    lv = l;
    g0 = gen_ticks;
    for (int n = 0; n < 5000 && gen_ticks < g0 + 2; n++) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wait_valid(input string req, output int t);
    int n;
    n = 0;
    while (!valid && n < WAIT_LIMIT) begin
      @(negedge clk);
      n++;
    end
    check({req, " valid arrives"}, int'(valid), 1);
    t = cyc;
  endtask

  initial begin
    repeat (10000 * 19) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual %0d expected %0d", cyc, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int t1;
    int t2;
    repeat (4) @(negedge clk);
    // R1: reset state
    check("R1 valid", int'(valid), 0);
    check("R1 count", int'(count), 0);
    check("R1 range", int'(range_code), 0);
    check("R1 overflow", int'(overflow), 0);
    check("R1 count_byte", int'(count_byte), 0);
    rst = 1'b0;

    // R3 R4 R7 R8: table walk
    for (int i = 0; i < NV; i++) begin
      set_input(V_HI[i], V_LO[i]);
      do_reset();
      wait_valid("R3", t1);
      check($sformatf("R3 range vec%0d", i), int'(range_code), V_RG[i]);
      check($sformatf("R7 count vec%0d", i), int'(count), V_CT[i]);
      check($sformatf("R8 overflow vec%0d", i), int'(overflow), V_OV[i]);
    end

    // R5: silent input still publishes at range 3
    set_input(0, 0);
    do_reset();
    wait_valid("R5", t1);
    check("R5 range", int'(range_code), 3);
    check("R5 count", int'(count), 0);
    check("R5 overflow", int'(overflow), 0);

    // R2 R9 R10: fast input, published at range 0
    set_input(2, 2);
    do_reset();
    wait_valid("R2", t1);
    hi_sel = 1'b0;
    @(negedge clk);
    check("R9 single cycle", int'(valid), 0);
    check("R9 count held", int'(count), 10);
    check("R10 low half", int'(count_byte), 2);
    hi_sel = 1'b1;
    @(negedge clk);
    check("R10 high half", int'(count_byte), 1);
    hi_sel = 1'b0;
    @(negedge clk);
    wait_valid("R2", t2);
    check("R2 interval", t2 - t1, BASE + 2);
    check("R2 range", int'(range_code), 0);

    // R6: publish at range 1, then restart at range 0
    set_input(5, 5);
    do_reset();
    wait_valid("R6", t1);
    @(negedge clk);
    wait_valid("R6", t2);
    check("R6 interval", t2 - t1, (BASE + 2) + (10 * BASE + 2));
    check("R6 range", int'(range_code), 1);
    check("R6 count", int'(count), 40);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule